// File: doc/BRIEF.md
# Bus Handoff Arbiter

This block sits beside a CPU and lends the system bus to one external master. The master pulls a request line low. After a programmable minimum delay the arbiter pulls its grant line low. Granting early does not free the bus at once. The CPU keeps its address and data drivers enabled while its own address strobe shows a cycle in flight. Only when that strobe reads high does the arbiter raise a float control that turns those drivers off.

The external master then confirms that it owns the bus by pulling an acknowledge line low. The arbiter answers by dropping its grant. It keeps the CPU floated until the acknowledge returns high, and then the CPU takes the bus back. A request withdrawn before any acknowledge sends the arbiter back to idle, and the CPU goes on driving.

All three control inputs are active-low. Each passes through its own synchroniser chain of `SYNC_STAGES` flops before the state machine uses it. `GRANT_LATENCY` sets how many cycles the state machine spends in the pending state before it grants.

Top module: `bus_handoff_arbiter`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `grant_n` is 1 and `bus_float` is 0.
- R2: With the defaults (`SYNC_STAGES`=2, `GRANT_LATENCY`=1), `grant_n` falls on the 4th rising edge after `req_n` goes low from idle, and is still 1 after the 3rd edge.
- R3: While the grant is active and `strobe_n` is held low, `bus_float` stays 0.
- R4: With the grant active, `bus_float` rises on the 3rd edge after `strobe_n` reads high, and not earlier. If `strobe_n` is already high when the grant starts, `bus_float` rises one edge after `grant_n` falls.
- R5: With the bus released, `grant_n` returns to 1 on the 3rd edge after `ack_n` goes low, and `bus_float` stays 1.
- R6: After the acknowledge, `bus_float` stays 1 for as long as `ack_n` is low, even if `req_n` goes high. It falls on the 3rd edge after `ack_n` returns high.
- R7: If `req_n` goes high before any acknowledge, then on the 3rd edge `grant_n` is 1 and `bus_float` is 0. This holds whether the arbiter is still waiting for the strobe or has already released the bus.
- R8: With no request pending, activity on `ack_n` or `strobe_n` leaves `grant_n` at 1 and `bus_float` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_n | input | 1 | Bus request from the external master, active low, asynchronous |
| ack_n | input | 1 | Acknowledge from the master that it owns the bus, active low, asynchronous |
| strobe_n | input | 1 | CPU address strobe, low while a CPU bus cycle is in flight |
| grant_n | output | 1 | Bus grant to the external master, active low |
| bus_float | output | 1 | High turns off the CPU address and data drivers |

## Verification
The assertions watch the synchronised view of the inputs and the state register. They assume the master follows the handshake. In particular, it pulls `ack_n` low only after `bus_float` has risen, and it keeps `req_n` low until it acknowledges or gives up. The directed stimulus follows that order in every scenario. Each input changes on the falling clock edge and is then held for several cycles, so every input passes cleanly through the synchronisers. The one deliberate break from the handshake is the idle case: there `ack_n` and `strobe_n` move with no request pending, and the state machine must ignore them.

// File: rtl/bha_pkg.sv
package bha_pkg;

    typedef enum logic [2:0] {
        ST_IDLE             = 3'd0,
        ST_GRANT_PENDING    = 3'd1,
        ST_WAIT_STROBE_HIGH = 3'd2,
        ST_RELEASED         = 3'd3,
        ST_RECLAIM          = 3'd4
    } hand_state_e;

    // synchronised control view, all active high
    typedef struct packed {
        logic req;
        logic ack;
        logic strobe_idle;
    } ctrl_t;

    function automatic logic grant_on(input hand_state_e s);
        return (s == ST_WAIT_STROBE_HIGH) || (s == ST_RELEASED);
    endfunction

    function automatic logic float_on(input hand_state_e s);
        return (s == ST_RELEASED) || (s == ST_RECLAIM);
    endfunction

endpackage

// File: rtl/bha_sync.sv
module bha_sync #(
    parameter int          WIDTH     = 3,
    parameter int          STAGES    = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= RST_VAL;
        else     chain[0] <= d;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= RST_VAL;
                else     chain[i] <= chain[i-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/bha_fsm.sv
module bha_fsm
    import bha_pkg::*;
#(
    parameter int GRANT_LATENCY = 1
) (
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctl,
    output logic  grant_act,
    output logic  float_act
);
    localparam int CNT_W = (GRANT_LATENCY < 2) ? 1 : $clog2(GRANT_LATENCY);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GRANT_LATENCY - 1);

    hand_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (ctl.req) state_d = ST_GRANT_PENDING;
            end
            ST_GRANT_PENDING: begin
                if (!ctl.req)             state_d = ST_IDLE;
                else if (cnt_q == CNT_LAST) state_d = ST_WAIT_STROBE_HIGH;
                else                      cnt_d = cnt_q + 1'b1;
            end
            ST_WAIT_STROBE_HIGH: begin
                if (!ctl.req)             state_d = ST_IDLE;
                else if (ctl.strobe_idle) state_d = ST_RELEASED;
            end
            ST_RELEASED: begin
                if (ctl.ack)       state_d = ST_RECLAIM;
                else if (!ctl.req) state_d = ST_IDLE;
            end
            ST_RECLAIM: begin
                if (!ctl.ack) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign grant_act = grant_on(state_q);
    assign float_act = float_on(state_q);

    // R2: the grant only starts after the pending state
    a_r2_grant_after_pending: assert property (@(posedge clk) disable iff (rst)
        $rose(grant_act) |-> $past(state_q) == ST_GRANT_PENDING);

    // R4: drivers only float once the strobe was seen idle
    a_r4_float_needs_strobe_idle: assert property (@(posedge clk) disable iff (rst)
        ($rose(float_act) && $past(state_q) == ST_WAIT_STROBE_HIGH) |-> $past(ctl.strobe_idle));

    // R5: an acknowledge in the released state withdraws the grant, bus stays floated
    a_r5_ack_drops_grant: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RELEASED && ctl.ack) |=> (!grant_act && float_act));

    // R6: floating holds while acknowledge stays asserted
    a_r6_float_held_during_ack: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RECLAIM && ctl.ack) |=> float_act);

    // R7: request withdrawn before acknowledge returns to idle
    a_r7_withdraw_to_idle: assert property (@(posedge clk) disable iff (rst)
        (!ctl.req && (state_q == ST_WAIT_STROBE_HIGH ||
                      (state_q == ST_RELEASED && !ctl.ack))) |=> state_q == ST_IDLE);

    // R8: idle without request stays idle
    a_r8_idle_without_req: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !ctl.req) |=> (!grant_act && !float_act));
endmodule

// File: rtl/bus_handoff_arbiter.sv
module bus_handoff_arbiter
    import bha_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int GRANT_LATENCY = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic req_n,
    input  logic ack_n,
    input  logic strobe_n,
    output logic grant_n,
    output logic bus_float
);
    localparam int NUM_IN = 3;

    logic [NUM_IN-1:0] raw_n, sync_n;
    ctrl_t ctl;
    logic  grant_act, float_act;

    assign raw_n = {req_n, ack_n, strobe_n};

    bha_sync #(
        .WIDTH  (NUM_IN),
        .STAGES (SYNC_STAGES),
        .RST_VAL({NUM_IN{1'b1}})
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (raw_n),
        .q  (sync_n)
    );

    assign ctl.req         = ~sync_n[2];
    assign ctl.ack         = ~sync_n[1];
    assign ctl.strobe_idle =  sync_n[0];

    bha_fsm #(
        .GRANT_LATENCY(GRANT_LATENCY)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .grant_act(grant_act),
        .float_act(float_act)
    );

    assign grant_n   = ~grant_act;
    assign bus_float = float_act;

    // R1: quiet outputs right after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (grant_n && !bus_float));

    // R3: drivers stay on while a CPU cycle is seen in flight before release
    a_r3_hold_while_strobe_low: assert property (@(posedge clk) disable iff (rst)
        (!grant_n && !bus_float && !ctl.strobe_idle) |=> !bus_float);
endmodule

// File: tb/sim_bus_handoff_arbiter.sv
module sim_bus_handoff_arbiter;
    logic clk = 1'b0;
    logic rst;
    logic req_n, ack_n, strobe_n;
    logic grant_n, bus_float;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    bus_handoff_arbiter u0 (
        .clk      (clk),
        .rst      (rst),
        .req_n    (req_n),
        .ack_n    (ack_n),
        .strobe_n (strobe_n),
        .grant_n  (grant_n),
        .bus_float(bus_float)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1; req_n = 1'b1; ack_n = 1'b1; strobe_n = 1'b1;
        edges(3);
        check(grant_n,   1'b1, "R1 grant_n in reset");
        check(bus_float, 1'b0, "R1 bus_float in reset");
        rst = 1'b0;
        edges(1);
        check(grant_n,   1'b1, "R1 grant_n after reset");
        check(bus_float, 1'b0, "R1 bus_float after reset");
    endtask

    task automatic t_full_handoff;
        strobe_n = 1'b1;
        req_n = 1'b0;
        edges(3);
        check(grant_n, 1'b1, "R2 grant not early");
        edges(1);
        check(grant_n,   1'b0, "R2 grant on 4th edge");
        check(bus_float, 1'b0, "R4 not floated with grant edge");
        edges(1);
        check(bus_float, 1'b1, "R4 float one edge after grant");
        ack_n = 1'b0;
        edges(2);
        check(grant_n, 1'b0, "R5 grant held before ack synced");
        edges(1);
        check(grant_n,   1'b1, "R5 grant dropped after ack");
        check(bus_float, 1'b1, "R5 float kept after ack");
        req_n = 1'b1;
        edges(5);
        check(bus_float, 1'b1, "R6 float held while ack low");
        ack_n = 1'b1;
        edges(2);
        check(bus_float, 1'b1, "R6 float before ack high synced");
        edges(1);
        check(bus_float, 1'b0, "R6 bus reclaimed");
        check(grant_n,   1'b1, "R6 grant idle after reclaim");
        edges(2);
    endtask

    task automatic t_strobe_busy;
        strobe_n = 1'b0;
        edges(3);
        req_n = 1'b0;
        edges(4);
        check(grant_n, 1'b0, "R2 grant with busy strobe");
        edges(5);
        check(bus_float, 1'b0, "R3 held while strobe low");
        strobe_n = 1'b1;
        edges(2);
        check(bus_float, 1'b0, "R4 not before strobe synced");
        edges(1);
        check(bus_float, 1'b1, "R4 float after strobe high");
        req_n = 1'b1;
        edges(2);
        check(bus_float, 1'b1, "R7 still released before withdraw synced");
        edges(1);
        check(bus_float, 1'b0, "R7 withdraw from released");
        check(grant_n,   1'b1, "R7 grant off after withdraw");
        edges(2);
    endtask

    task automatic t_withdraw_waiting;
        strobe_n = 1'b0;
        edges(3);
        req_n = 1'b0;
        edges(4);
        check(grant_n, 1'b0, "R2 grant before withdraw");
        req_n = 1'b1;
        edges(3);
        check(grant_n,   1'b1, "R7 grant off while waiting");
        check(bus_float, 1'b0, "R7 driving after withdraw");
        strobe_n = 1'b1;
        edges(5);
        check(bus_float, 1'b0, "R8 strobe alone no release");
    endtask

    task automatic t_no_request;
        ack_n = 1'b0;
        strobe_n = 1'b0;
        edges(3);
        strobe_n = 1'b1;
        edges(4);
        check(grant_n,   1'b1, "R8 no grant without request");
        check(bus_float, 1'b0, "R8 no float without request");
        ack_n = 1'b1;
        edges(3);
        check(bus_float, 1'b0, "R8 still driving");
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
            finish_run();
        end
    end

    initial begin
        t_reset();
        t_full_handoff();
        t_strobe_busy();
        t_withdraw_waiting();
        t_no_request();
        finish_run();
    end
endmodule